// File: doc/BRIEF.md
# Variable Page Size TLB Lookup

This block is a small, fully associative translation buffer. It turns a process identifier and an effective address into a physical address. Every slot holds a valid flag, a page tag, a size code, an owner identifier, a real page number and three permission bits. On each lookup all slots are compared at the same time. A slot's own size code sets how many low tag bits take no part in its compare.

A slot that matches supplies the upper part of the physical address, and the effective address supplies the page offset. If the slot's permissions forbid the requested kind of access, a fault is reported. If no slot matches, a miss is reported. When translation is switched off, the address passes through untouched and no checks are made.

Slots are loaded through a single-cycle write port. A lookup is evaluated combinationally and its result appears on registered outputs one cycle later.

Top module: `vpage_tlb`

## Requirements
- R1: After reset every slot is invalid, so a translated lookup misses. All result outputs are 0 while reset is held.
- R2: A slot hits only when all three of these hold: it is valid, its tag equals the effective page number (`req_ea[31:10]`) outside its masked low bits, and its owner ID equals `req_pid`. The number of masked low bits is 2 × size code.
- R3: A slot whose owner ID is 0 skips the ID compare and hits for any `req_pid`.
- R4: When `req_pid` is 0, only slots with owner ID 0 can hit.
- R5: If no slot hits on a translated lookup, the result has `o_miss`=1, `o_hit`=0, `o_fault`=0 and `o_pa`=0.
- R6: On a permitted hit, the page offset width is 10 + 2 × size code bits, for size codes 0 to 7 (1 kB up to 16 MB). `o_pa` takes the real page number bits above that offset and takes the offset bits from `req_ea`.
- R7: `wr_perm` bit 0 allows read, bit 1 allows write and bit 2 allows execute. `req_kind` 0 is read, 1 is write, 2 is execute and 3 is treated as read. A hit whose required bit is clear gives `o_hit`=1, `o_fault`=1 and `o_pa`=0.
- R8: With `xlat_en`=0 a lookup gives `o_pa` = `req_ea` with hit, miss and fault all 0.
- R9: A lookup presented with `req_valid`=1 gives `o_valid`=1 and its result on the next cycle. With no request, `o_valid` and the other results are 0 on the next cycle.
- R10: A write with `wr_en`=1 replaces slot `wr_idx` from the next cycle on. Writing with `wr_valid`=0 removes the slot from matching.
- R11: Real page number bits below the page boundary of a slot do not affect `o_pa`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write a slot this cycle |
| wr_idx | input | 3 | Slot index to write |
| wr_valid | input | 1 | Valid flag for the written slot |
| wr_tag | input | 22 | Page tag (effective address bits 31:10) |
| wr_size | input | 3 | Size code 0..7 |
| wr_tid | input | 8 | Owner ID, 0 marks a global slot |
| wr_rpn | input | 22 | Real page number (physical bits 31:10) |
| wr_perm | input | 3 | Permission bits {execute, write, read} |
| xlat_en | input | 1 | Translation enable, 0 selects pass-through |
| req_valid | input | 1 | Lookup request |
| req_pid | input | 8 | Current process ID |
| req_ea | input | 32 | Effective address |
| req_kind | input | 2 | Access kind: 0 read, 1 write, 2 execute, 3 read |
| o_valid | output | 1 | Result valid |
| o_hit | output | 1 | A slot matched |
| o_miss | output | 1 | No slot matched |
| o_fault | output | 1 | Permission violation on a hit |
| o_pa | output | 32 | Physical address |

## Verification
The bench builds the block with 8 slots, 8-bit process IDs, 32-bit addresses, a 1 kB minimum page, a size step of two bits and 8 size codes. With 8 slots there is room for side-by-side slots at the smallest, a middle (256 kB) and the largest page size, a global slot, and an invalidated slot whose tag would otherwise match. The 32-bit address puts the 16 MB page offset (24 bits) and a 256 kB slot holding nonzero real page number bits below its boundary within reach. Together these exercise every masking width boundary that the vectors touch.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
   // permission bit positions inside an entry
   localparam int PERM_W   = 3;
   localparam int PERM_RD  = 0;
   localparam int PERM_WR  = 1;
   localparam int PERM_EX  = 2;

   typedef enum logic [1:0] {
      ACC_READ  = 2'd0,
      ACC_WRITE = 2'd1,
      ACC_EXEC  = 2'd2,
      ACC_ALT   = 2'd3
   } acc_kind_e;

   // required permission bit for a given access kind
   function automatic int perm_bit(input logic [1:0] kind);
      case (kind)
         2'd1:    return PERM_WR;
         2'd2:    return PERM_EX;
         default: return PERM_RD;
      endcase
   endfunction
endpackage

// File: rtl/tlb_entry_cmp.sv
module tlb_entry_cmp #(
   parameter int TAG_W     = 22,
   parameter int PID_W     = 8,
   parameter int SZ_W      = 3,
   parameter int SIZE_STEP = 2
) (
   input  logic             ent_valid,
   input  logic [TAG_W-1:0] ent_tag,
   input  logic [SZ_W-1:0]  ent_size,
   input  logic [PID_W-1:0] ent_tid,
   input  logic [PID_W-1:0] pid,
   input  logic [TAG_W-1:0] epn,
   output logic             match
);
   logic [TAG_W-1:0] keep;
   logic             tag_ok;
   logic             id_ok;

   always_comb begin
      keep   = {TAG_W{1'b1}} << (int'(ent_size) * SIZE_STEP);
      tag_ok = ((ent_tag ^ epn) & keep) == '0;
      // zero owner ID is global; a zero pid therefore reaches only global slots
      id_ok  = (ent_tid == '0) || (ent_tid == pid);
      match  = ent_valid && tag_ok && id_ok;
   end
endmodule

// File: rtl/tlb_pick.sv
module tlb_pick #(
   parameter int N = 8
) (
   input  logic [N-1:0] req,
   output logic [N-1:0] gnt,
   output logic         any
);
   always_comb begin
      gnt = '0;
      any = 1'b0;
      for (int i = 0; i < N; i++) begin
         if (req[i] && !any) begin
            gnt[i] = 1'b1;
            any    = 1'b1;
         end
      end
   end
endmodule

// File: rtl/vpage_tlb.sv
module vpage_tlb
   import tlb_pkg::*;
#(
   parameter  int ENTRIES    = 8,
   parameter  int EA_W       = 32,
   parameter  int PID_W      = 8,
   parameter  int PAGE_MIN   = 10,
   parameter  int SIZE_STEP  = 2,
   parameter  int SIZE_CODES = 8,
   localparam int IDX_W      = $clog2(ENTRIES),
   localparam int SZ_W       = $clog2(SIZE_CODES),
   localparam int TAG_W      = EA_W - PAGE_MIN
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic              wr_valid,
   input  logic [TAG_W-1:0]  wr_tag,
   input  logic [SZ_W-1:0]   wr_size,
   input  logic [PID_W-1:0]  wr_tid,
   input  logic [TAG_W-1:0]  wr_rpn,
   input  logic [PERM_W-1:0] wr_perm,
   input  logic              xlat_en,
   input  logic              req_valid,
   input  logic [PID_W-1:0]  req_pid,
   input  logic [EA_W-1:0]   req_ea,
   input  logic [1:0]        req_kind,
   output logic              o_valid,
   output logic              o_hit,
   output logic              o_miss,
   output logic              o_fault,
   output logic [EA_W-1:0]   o_pa
);
   // elaboration-time parameter checks
   if (ENTRIES < 2) begin : g_bad_entries
      $error("vpage_tlb: ENTRIES must be at least 2");
   end
   if (PAGE_MIN + SIZE_STEP * (SIZE_CODES - 1) > EA_W) begin : g_bad_span
      $error("vpage_tlb: largest page exceeds address width");
   end
   if (SIZE_CODES < 2) begin : g_bad_sizes
      $error("vpage_tlb: need at least two size codes");
   end

   // slot storage
   logic              ent_v    [ENTRIES];
   logic [TAG_W-1:0]  ent_tag  [ENTRIES];
   logic [SZ_W-1:0]   ent_size [ENTRIES];
   logic [PID_W-1:0]  ent_tid  [ENTRIES];
   logic [TAG_W-1:0]  ent_rpn  [ENTRIES];
   logic [PERM_W-1:0] ent_perm [ENTRIES];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < ENTRIES; i++) ent_v[i] <= 1'b0;
      end else if (wr_en) begin
         ent_v   [wr_idx] <= wr_valid;
         ent_tag [wr_idx] <= wr_tag;
         ent_size[wr_idx] <= wr_size;
         ent_tid [wr_idx] <= wr_tid;
         ent_rpn [wr_idx] <= wr_rpn;
         ent_perm[wr_idx] <= wr_perm;
      end
   end

   // parallel compare
   logic [ENTRIES-1:0] match;
   logic [TAG_W-1:0]   epn;
   assign epn = req_ea[EA_W-1:PAGE_MIN];

   for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
      tlb_entry_cmp #(
         .TAG_W(TAG_W), .PID_W(PID_W), .SZ_W(SZ_W), .SIZE_STEP(SIZE_STEP)
      ) u_cmp (
         .ent_valid(ent_v[g]),
         .ent_tag  (ent_tag[g]),
         .ent_size (ent_size[g]),
         .ent_tid  (ent_tid[g]),
         .pid      (req_pid),
         .epn      (epn),
         .match    (match[g])
      );
   end

   // lowest index wins when several slots match
   logic [ENTRIES-1:0] gnt;
   logic               any_hit;
   tlb_pick #(.N(ENTRIES)) u_pick (.req(match), .gnt(gnt), .any(any_hit));

   // selected slot fields
   logic [TAG_W-1:0]  sel_rpn;
   logic [SZ_W-1:0]   sel_size;
   logic [PERM_W-1:0] sel_perm;
   always_comb begin
      sel_rpn  = '0;
      sel_size = '0;
      sel_perm = '0;
      for (int i = 0; i < ENTRIES; i++) begin
         if (gnt[i]) begin
            sel_rpn  |= ent_rpn[i];
            sel_size |= ent_size[i];
            sel_perm |= ent_perm[i];
         end
      end
   end

   // address merge and permission test
   logic [EA_W-1:0] hi_mask;
   logic [EA_W-1:0] xl_pa;
   logic            perm_ok;
   always_comb begin
      hi_mask = {EA_W{1'b1}} << (PAGE_MIN + SIZE_STEP * int'(sel_size));
      xl_pa   = ({sel_rpn, {PAGE_MIN{1'b0}}} & hi_mask) | (req_ea & ~hi_mask);
      perm_ok = sel_perm[perm_bit(req_kind)];
   end

   // registered result
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         o_valid <= 1'b0;
         o_hit   <= 1'b0;
         o_miss  <= 1'b0;
         o_fault <= 1'b0;
         o_pa    <= '0;
      end else begin
         o_valid <= req_valid;
         o_hit   <= req_valid && xlat_en && any_hit;
         o_miss  <= req_valid && xlat_en && !any_hit;
         o_fault <= req_valid && xlat_en && any_hit && !perm_ok;
         if (!req_valid)
            o_pa <= '0;
         else if (!xlat_en)
            o_pa <= req_ea;
         else if (any_hit && perm_ok)
            o_pa <= xl_pa;
         else
            o_pa <= '0;
      end
   end

   // assertions
   p_valid_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> o_valid);
   p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> (!o_valid && !o_hit && !o_miss && !o_fault));
   p_real_pass_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !xlat_en) |=>
         (o_pa == $past(req_ea) && !o_hit && !o_miss && !o_fault));
   p_offset_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && xlat_en && any_hit && perm_ok) |=>
         (o_pa[PAGE_MIN-1:0] == $past(req_ea[PAGE_MIN-1:0])));
   p_miss_clean_r5: assert property (@(posedge clk) disable iff (!rst_n)
      o_miss |-> (!o_hit && !o_fault && o_pa == '0));
   p_fault_on_hit_r7: assert property (@(posedge clk) disable iff (!rst_n)
      o_fault |-> (o_hit && o_pa == '0));
   p_one_winner_r2: assert property (@(posedge clk) disable iff (!rst_n)
      any_hit |-> ($onehot(gnt) && (gnt & ~match) == '0));
endmodule

// File: tb/vpage_tlb_bench.sv
module vpage_tlb_bench;
   localparam int ENTRIES = 8;
   localparam int EA_W    = 32;
   localparam int PID_W   = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_idx = '0;
   logic        wr_valid = 1'b0;
   logic [21:0] wr_tag = '0;
   logic [2:0]  wr_size = '0;
   logic [7:0]  wr_tid = '0;
   logic [21:0] wr_rpn = '0;
   logic [2:0]  wr_perm = '0;
   logic        xlat_en = 1'b0;
   logic        req_valid = 1'b0;
   logic [7:0]  req_pid = '0;
   logic [31:0] req_ea = '0;
   logic [1:0]  req_kind = '0;
   logic        o_valid, o_hit, o_miss, o_fault;
   logic [31:0] o_pa;

   always #10 clk = ~clk;   // 50 MHz

   vpage_tlb #(
      .ENTRIES(ENTRIES), .EA_W(EA_W), .PID_W(PID_W),
      .PAGE_MIN(10), .SIZE_STEP(2), .SIZE_CODES(8)
   ) u_vpage_tlb (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en), .wr_idx(wr_idx), .wr_valid(wr_valid), .wr_tag(wr_tag),
      .wr_size(wr_size), .wr_tid(wr_tid), .wr_rpn(wr_rpn), .wr_perm(wr_perm),
      .xlat_en(xlat_en), .req_valid(req_valid), .req_pid(req_pid),
      .req_ea(req_ea), .req_kind(req_kind),
      .o_valid(o_valid), .o_hit(o_hit), .o_miss(o_miss), .o_fault(o_fault),
      .o_pa(o_pa)
   );

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   typedef struct packed {
      logic        xl;
      logic [7:0]  pid;
      logic [31:0] ea;
      logic [1:0]  kind;
      logic        hit;
      logic        miss;
      logic        fault;
      logic [31:0] pa;
      logic [3:0]  rq;
   } vec_t;

   localparam int NV = 14;
   localparam vec_t VECS [NV] = '{
      // R2: 1 kB owned slot, read
      '{1'b1, 8'd5, 32'h0001_0123, 2'd0, 1'b1, 1'b0, 1'b0, 32'h8000_0123, 4'd2},
      // R7: write allowed
      '{1'b1, 8'd5, 32'h0001_0123, 2'd1, 1'b1, 1'b0, 1'b0, 32'h8000_0123, 4'd7},
      // R7: execute forbidden
      '{1'b1, 8'd5, 32'h0001_0123, 2'd2, 1'b1, 1'b0, 1'b1, 32'h0000_0000, 4'd7},
      // R2: owner mismatch
      '{1'b1, 8'd6, 32'h0001_0123, 2'd0, 1'b0, 1'b1, 1'b0, 32'h0000_0000, 4'd2},
      // R2: tag mismatch just past 1 kB page
      '{1'b1, 8'd5, 32'h0001_0400, 2'd0, 1'b0, 1'b1, 1'b0, 32'h0000_0000, 4'd2},
      // R3 and R11: global 256 kB slot with junk low page-number bits
      '{1'b1, 8'd6, 32'h0043_2345, 2'd0, 1'b1, 1'b0, 1'b0, 32'h1203_2345, 4'd3},
      // R4: pid 0 reaches global slot
      '{1'b1, 8'd0, 32'h0043_2345, 2'd0, 1'b1, 1'b0, 1'b0, 32'h1203_2345, 4'd4},
      // R4: pid 0 cannot reach owned slot
      '{1'b1, 8'd0, 32'h0001_0123, 2'd0, 1'b0, 1'b1, 1'b0, 32'h0000_0000, 4'd4},
      // R6: 16 MB slot, execute
      '{1'b1, 8'd9, 32'h05AB_CDEF, 2'd2, 1'b1, 1'b0, 1'b0, 32'hABAB_CDEF, 4'd6},
      // R7: 16 MB slot, read forbidden
      '{1'b1, 8'd9, 32'h05AB_CDEF, 2'd0, 1'b1, 1'b0, 1'b1, 32'h0000_0000, 4'd7},
      // R10: slot written invalid does not match
      '{1'b1, 8'd5, 32'h0002_0010, 2'd0, 1'b0, 1'b1, 1'b0, 32'h0000_0000, 4'd10},
      // R8: pass-through
      '{1'b0, 8'd3, 32'hDEAD_BEEF, 2'd0, 1'b0, 1'b0, 1'b0, 32'hDEAD_BEEF, 4'd8},
      // R5: just above the 256 kB page
      '{1'b1, 8'd5, 32'h0044_0000, 2'd0, 1'b0, 1'b1, 1'b0, 32'h0000_0000, 4'd5},
      // R7: kind 3 treated as read
      '{1'b1, 8'd5, 32'h0001_0123, 2'd3, 1'b1, 1'b0, 1'b0, 32'h8000_0123, 4'd7}
   };

   task automatic check(input int rq, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL R%0d %s: actual=%h expected=%h", rq, what, act, exp);
      end
   endtask

   task automatic write_slot(input logic [2:0] idx, input logic v,
                             input logic [21:0] tag, input logic [2:0] sz,
                             input logic [7:0] tid, input logic [21:0] rpn,
                             input logic [2:0] perm);
      @(negedge clk);
      wr_en = 1'b1; wr_idx = idx; wr_valid = v; wr_tag = tag;
      wr_size = sz; wr_tid = tid; wr_rpn = rpn; wr_perm = perm;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   // presents one lookup, samples the registered result after one edge
   task automatic lookup(input logic xl, input logic [7:0] pid,
                         input logic [31:0] ea, input logic [1:0] kind);
      @(negedge clk);
      xlat_en = xl; req_pid = pid; req_ea = ea; req_kind = kind;
      req_valid = 1'b1;
      @(posedge clk);
      #5;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic check_result(input int rq, input vec_t v);
      check(rq, "o_valid", 32'(o_valid), 32'd1);
      check(rq, "o_hit",   32'(o_hit),   32'(v.hit));
      check(rq, "o_miss",  32'(o_miss),  32'(v.miss));
      check(rq, "o_fault", 32'(o_fault), 32'(v.fault));
      check(rq, "o_pa",    o_pa,         v.pa);
   endtask

   task automatic lookup_check(input vec_t v);
      @(negedge clk);
      xlat_en = v.xl; req_pid = v.pid; req_ea = v.ea; req_kind = v.kind;
      req_valid = 1'b1;
      @(posedge clk);
      #5;
      check_result(int'(v.rq), v);
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin : main
      vec_t exp;
      repeat (3) @(posedge clk);
      #5;
      // R1: outputs low during reset
      check(1, "o_valid in reset", 32'(o_valid), 32'd0);
      check(1, "o_pa in reset", o_pa, 32'd0);
      @(negedge clk);
      rst_n = 1'b1;

      // R1: empty buffer misses
      exp = '{1'b1, 8'd0, 32'h0043_2345, 2'd0, 1'b0, 1'b1, 1'b0, 32'h0, 4'd1};
      lookup_check(exp);

      // load slots
      write_slot(3'd0, 1'b1, 22'h000040, 3'd0, 8'd5, 22'h200000, 3'b011);
      write_slot(3'd1, 1'b1, 22'h001000, 3'd4, 8'd0, 22'h0480FF, 3'b111);
      write_slot(3'd2, 1'b1, 22'h014000, 3'd7, 8'd9, 22'h2AC000, 3'b100);
      write_slot(3'd3, 1'b0, 22'h000080, 3'd0, 8'd5, 22'h300000, 3'b111);

      for (int i = 0; i < NV; i++) lookup_check(VECS[i]);

      // R9: result appears exactly one edge after the request
      @(negedge clk);
      xlat_en = 1'b1; req_pid = 8'd5; req_ea = 32'h0001_0123; req_kind = 2'd0;
      req_valid = 1'b1;
      #1;
      check(9, "o_valid before edge", 32'(o_valid), 32'd0);
      @(posedge clk);
      #5;
      check(9, "o_valid after edge", 32'(o_valid), 32'd1);
      check(9, "o_pa after edge", o_pa, 32'h8000_0123);
      @(negedge clk);
      req_valid = 1'b0;
      @(posedge clk);
      #5;
      check(9, "o_valid idle", 32'(o_valid), 32'd0);
      check(9, "o_hit idle", 32'(o_hit), 32'd0);

      // R10: invalidate slot 0 then re-enable slot 3
      write_slot(3'd0, 1'b0, 22'h000040, 3'd0, 8'd5, 22'h200000, 3'b011);
      exp = '{1'b1, 8'd5, 32'h0001_0123, 2'd0, 1'b0, 1'b1, 1'b0, 32'h0, 4'd10};
      lookup_check(exp);
      write_slot(3'd3, 1'b1, 22'h000080, 3'd0, 8'd5, 22'h300000, 3'b111);
      exp = '{1'b1, 8'd5, 32'h0002_0010, 2'd0, 1'b1, 1'b0, 1'b0, 32'hC000_0010, 4'd10};
      lookup_check(exp);

      // R6: 4 kB page (code 1) keeps 12 offset bits
      write_slot(3'd4, 1'b1, 22'h000400, 3'd1, 8'd7, 22'h012345, 3'b001);
      exp = '{1'b1, 8'd7, 32'h0010_0ABC, 2'd0, 1'b1, 1'b0, 1'b0, 32'h048D_1ABC, 4'd6};
      lookup_check(exp);

      // R1: reset clears every slot
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      exp = '{1'b1, 8'd6, 32'h0043_2345, 2'd0, 1'b0, 1'b1, 1'b0, 32'h0, 4'd1};
      lookup_check(exp);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule